// File: doc/BRIEF.md
# Inverting Byte Path with Sequence-Armed Pass-Through

This block is a clocked 8-bit datapath. In normal operation each input byte comes out one clock later with every bit flipped. In parallel, a small detector watches the input stream for a fixed run of three bytes on consecutive clocks: 0x21, then 0xF1, then 0x37.

When the full run has been seen, the detector arms a countdown. The countdown is loaded from a free-running 4-bit pseudo-random register, so the wait is between 1 and 15 cycles. When the countdown ends, the datapath switches to copying input bytes straight to the output, unchanged. It stays in that mode until the synchronous reset. The last byte of the run is never copied out: the switch takes effect only on bytes that arrive after the countdown.

The port list is the same as that of a plain registered inverter: clock, reset, byte in and byte out.

Top module: `seqov_inverter`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` becomes 0x00 after that edge, the detector returns to its idle state and any countdown or pass-through mode is cleared.
- R2: Outside pass-through mode, `dout` after a rising edge equals the bitwise complement of the `din` sampled at that edge, so there is one cycle of latency.
- R3: The bytes 0x21, 0xF1 and 0x37, sampled on three consecutive rising edges, arm the countdown.
- R4: A sampled byte that does not continue the run sends the detector back to idle. The exception is 0x21, which always counts as the first byte of a new run. So 21 21 F1 37 arms, and 21 F1 21 F1 37 arms.
- R5: Incomplete or broken runs never arm. Examples are 21 F1 followed by another byte and then 37, a run with its middle byte missing, or 37 alone. After such a run every later byte comes out inverted.
- R6: The final 0x37 of an arming run comes out as its complement 0xC8. So does the first byte sampled after it.
- R7: Call the 0x37 byte 0 and count the bytes sampled after it from 1. The first byte copied through unchanged is one of bytes 2 to 16. The wait comes from a 4-bit pseudo-random register that is never zero.
- R8: Once pass-through mode has begun, every later byte appears unchanged on `dout` one cycle after it is sampled, until reset.
- R9: A reset that is high on the same edge as the final 0x37 wins: nothing is armed, and afterwards the output is inverted again. A reset given after pass-through has begun also brings back inversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Input byte, sampled every rising edge |
| dout | output | 8 | Registered output byte: inverted, or copied once pass-through has begun |

## Verification
Two events can land on the same edge. One is completion of the three-byte run, which loads the countdown. The other is either the synchronous reset or the restart of the detector on a fresh 0x21 byte. The bench holds `rst` high on the very edge where 0x37 completes a run. It then judges the outcome at the ports: the output must be 0x00 on the following cycle, and a long stream of filler bytes afterwards must stay inverted. The bench also places 0x21 where a mismatch would otherwise reset the detector. Here the run must still arm, so that the filler stream that follows switches to pass-through within the allowed window.

// File: rtl/seqov_pkg.sv
package seqov_pkg;
  localparam int BYTE_W = 8;
  localparam int LFSR_W = 4;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 4'b0001;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef enum logic [1:0] {
    DET_IDLE,
    DET_SAW_A,
    DET_SAW_AB,
    DET_ARMED
  } det_state_e;

  // maximal-length 4-bit shift register, taps x^4 + x^3 + 1; never reaches zero
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction

  // next detector state; a fresh first key byte always restarts the run
  function automatic det_state_e det_next(input det_state_e cur, input byte_t b,
                                          input byte_t k0, input byte_t k1,
                                          input byte_t k2);
    det_state_e nx;
    case (cur)
      DET_ARMED:  nx = DET_ARMED;
      DET_SAW_AB: nx = (b == k2) ? DET_ARMED : ((b == k0) ? DET_SAW_A : DET_IDLE);
      DET_SAW_A:  nx = (b == k1) ? DET_SAW_AB : ((b == k0) ? DET_SAW_A : DET_IDLE);
      default:    nx = (b == k0) ? DET_SAW_A : DET_IDLE;
    endcase
    return nx;
  endfunction

  function automatic byte_t shape_out(input logic pass, input byte_t b);
    return pass ? b : ~b;
  endfunction
endpackage

// File: rtl/seqov_detect.sv
module seqov_detect
  import seqov_pkg::*;
#(
  parameter byte_t KEY0 = 8'h21,
  parameter byte_t KEY1 = 8'hF1,
  parameter byte_t KEY2 = 8'h37
) (
  input  logic  clk,
  input  logic  rst,
  input  byte_t din,
  output logic  arm_hit
);
  det_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= DET_IDLE;
    else     st_q <= det_next(st_q, din, KEY0, KEY1, KEY2);
  end

  // completion of the run, seen in the cycle the final byte is presented
  assign arm_hit = (st_q == DET_SAW_AB) && (din == KEY2);
endmodule

// File: rtl/seqov_delay.sv
module seqov_delay
  import seqov_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm_hit,
  output logic ovr_on
);
  lfsr_t rnd_q;
  lfsr_t cnt_q;
  logic  pend_q;
  logic  on_q;

  always_ff @(posedge clk) begin
    if (rst) rnd_q <= LFSR_SEED;
    else     rnd_q <= lfsr_step(rnd_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      on_q   <= 1'b0;
    end else if (arm_hit && !pend_q && !on_q) begin
      cnt_q  <= rnd_q;
      pend_q <= 1'b1;
    end else if (pend_q) begin
      if (cnt_q <= lfsr_t'(1)) begin
        cnt_q  <= '0;
        pend_q <= 1'b0;
        on_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_q - lfsr_t'(1);
      end
    end
  end

  assign ovr_on = on_q;
endmodule

// File: rtl/seqov_outsel.sv
module seqov_outsel
  import seqov_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pass,
  input  byte_t din,
  output byte_t dout
);
  byte_t q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= shape_out(pass, din);
  end

  assign dout = q;
endmodule

// File: rtl/seqov_inverter.sv
module seqov_inverter
  import seqov_pkg::*;
#(
  parameter byte_t KEY0 = 8'h21,
  parameter byte_t KEY1 = 8'hF1,
  parameter byte_t KEY2 = 8'h37
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic trig_hit;
  logic ovr_active;

  seqov_detect #(.KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)) u_det (
    .clk(clk), .rst(rst), .din(din), .arm_hit(trig_hit)
  );

  seqov_delay u_dly (
    .clk(clk), .rst(rst), .arm_hit(trig_hit), .ovr_on(ovr_active)
  );

  seqov_outsel u_out (
    .clk(clk), .rst(rst), .pass(ovr_active), .din(din), .dout(dout)
  );
endmodule

// File: rtl/seqov_inverter_chk.sv
module seqov_inverter_chk #(
  parameter logic [7:0] KEY2 = 8'h37
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       trig_hit,
  input logic       ovr_active
);
  localparam int SW = 5;
  localparam logic [SW-1:0] SMAX = '1;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst)                                  since_q <= '0;
    else if (trig_hit && since_q == '0)       since_q <= SW'(1);
    else if (since_q != '0 && since_q != SMAX) since_q <= since_q + SW'(1);
  end

  // R2: inverted path while not overriding
  p_invert_r2: assert property (@(posedge clk) disable iff (rst)
    !ovr_active |=> dout == ~$past(din));

  // R8: copy path once overriding
  p_pass_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_active |=> dout == $past(din));

  // R8: override persists
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_active |=> ovr_active);

  // R6: final trigger byte is never copied out
  p_no_key_r6: assert property (@(posedge clk) disable iff (rst)
    trig_hit |=> (dout == ~KEY2) && !ovr_active);

  // R7: override begins 1..15 cycles after arming
  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_active) |-> (since_q >= SW'(2)) && (since_q <= SW'(16)));

  // R1: reset clears output
  p_reset_r1: assert property (@(posedge clk)
    rst |=> dout == 8'h00);
endmodule

bind seqov_inverter seqov_inverter_chk #(.KEY2(KEY2)) u_chk (
  .clk(clk), .rst(rst), .din(din), .dout(dout),
  .trig_hit(trig_hit), .ovr_active(ovr_active)
);

// File: tb/tb_seqov_inverter.sv
module tb_seqov_inverter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV = 8;
  localparam logic [7:0] VEC_IN  [NV] = '{8'h00, 8'h21, 8'hFF, 8'hF1, 8'hA5, 8'h37, 8'h3C, 8'h80};
  localparam logic [7:0] VEC_EXP [NV] = '{8'hFF, 8'hDE, 8'h00, 8'h0E, 8'h5A, 8'hC8, 8'hC3, 8'h7F};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  seqov_inverter dut (.clk(clk), .rst(rst), .din(din), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] b, output logic [7:0] got);
    din = b;
    @(negedge clk);
    got = dout;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din = 8'h37;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "dout under reset", dout, 8'h00);
    rst = 1'b0;
  endtask

  // fillers 0x41.. never contain a key byte
  task automatic fill_inverted(input string req, input int n);
    logic [7:0] g;
    for (int j = 1; j <= n; j++) begin
      step(8'(8'h40 + j), g);
      chk(req, "filler stays inverted", g, ~8'(8'h40 + j));
    end
  endtask

  task automatic post_trigger(input string req);
    logic [7:0] g;
    logic [7:0] b;
    int first = 0;
    for (int j = 1; j <= 20; j++) begin
      b = 8'(8'h40 + j);
      step(b, g);
      if (first == 0 && g == b) first = j;
      if (first == 0) chk(req, "byte before override inverted", g, ~b);
      else            chk("R8", "byte copied after override", g, b);
    end
    n_chk++;
    if (first < 2 || first > 16) begin
      n_err++;
      $display("FAIL R7 first pass-through index: got=%0d expected=2..16", first);
    end
  endtask

  task automatic send_run(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [7:0] g;
    step(a, g);
    step(b, g);
    step(c, g);
    chk("R6", "final run byte output", g, ~c);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    do_reset();

    // R2: table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC_IN[i], g);
      chk("R2", "inverted vector", g, VEC_EXP[i]);
    end

    // R5: broken runs
    do_reset();
    send_run(8'h21, 8'hF1, 8'h00);
    step(8'h37, g); chk("R5", "37 after break", g, 8'hC8);
    fill_inverted("R5", 20);
    send_run(8'h21, 8'h37, 8'h00);
    send_run(8'hF1, 8'h37, 8'h37);
    fill_inverted("R5", 20);

    // R3 + R6 + R7 + R8: plain run
    do_reset();
    send_run(8'h21, 8'hF1, 8'h37);
    post_trigger("R3");

    // R9: reset after override restores inversion
    do_reset();
    fill_inverted("R9", 20);

    // R4: repeated first byte
    do_reset();
    step(8'h21, g);
    send_run(8'h21, 8'hF1, 8'h37);
    post_trigger("R4");

    // R4: restart in the middle of a run
    do_reset();
    step(8'h21, g);
    step(8'hF1, g);
    send_run(8'h21, 8'hF1, 8'h37);
    post_trigger("R4");

    // R9: reset on the same edge as the final key byte
    do_reset();
    step(8'h21, g);
    step(8'hF1, g);
    rst = 1'b1;
    din = 8'h37;
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "reset wins over final byte", dout, 8'h00);
    fill_inverted("R9", 20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule